// File: doc/BRIEF.md
# Smart Card Channel Status Flags

This block keeps the status byte of a half-duplex smart card serial channel. It gathers events from the transmit and receive datapaths into sticky flags: transmit buffer empty, receive buffer full, overrun, error signal seen, parity error and transmit end. It also holds the multiprocessor bit of the last accepted character and a software-written multiprocessor bit for the next transmitted one. A processor reads the whole byte at once. It clears a flag by writing a 0 to it after a read has shown that flag as 1. DMA strobes on the data registers clear the buffer flags directly.

The block also decides what the receive datapath may do with each finished character. It raises `rx_store` when the byte belongs in the receive data register and `rx_blocked` when reception is frozen. A built-in timer counts half elementary time units (etu) after each transmitted character and raises transmit end after a guard delay. The length of that delay depends on the guard and block mode inputs.

Top module: `sc_status_reg`

## Requirements
- R1: After reset the status byte reads 8'h84. Bit 7 is transmit-empty, bit 6 receive-full, bit 5 overrun, bit 4 error-signal, bit 3 parity-error, bit 2 transmit-end, bit 1 received multiprocessor bit and bit 0 transmit multiprocessor bit.
- R2: A processor write clears a flag in bits 7..3 only if that bit of the written data is 0 and a processor read since the flag last went to 0 returned it as 1. Writing 1, or writing 0 with no such read, leaves the flag unchanged.
- R3: Transmit-empty becomes 1 on a cycle where `tx_en` is 0 or `tx_load` is high. It becomes 0 on a DMA write to the transmit data register or on the processor clear sequence of R2. The set wins over the clear.
- R4: With guard mode 0 and block mode 0, transmit-end rises 5 half-etu (2.5 etu) after `tx_char_done`, provided transmit-empty is 1 and error-signal is 0 when the delay ends. Half an etu is `etu_cycles/2` clock cycles.
- R5: With guard mode 0 and block mode 1, the delay of R4 is 3 half-etu (1.5 etu).
- R6: With guard mode 1, the delay of R4 is 2 half-etu (1.0 etu) for either block mode.
- R7: Transmit-end is cleared by the same events that clear transmit-empty. It is set while `tx_en` is 0 only if error-signal is 0. A write of the transmit data register by the processor or by DMA cancels a pending delay.
- R8: A character that is accepted and fails the parity check sets parity-error and pulses `rx_store`, and receive-full stays 0. While parity-error is 1, later characters are ignored.
- R9: A character that finishes while receive-full is 1 sets overrun, leaves `rx_store` low and discards the byte. While overrun is 1, later characters are ignored.
- R10: A character that is accepted and passes the parity check pulses `rx_store` and sets receive-full. A DMA read of the receive data register clears receive-full.
- R11: `err_sig_low` sets error-signal, and clearing `tx_en` leaves it unchanged. While `rx_en` is 0, `rx_done` has no effect on any receive flag.
- R12: Bit 1 takes `rx_mpb` of each stored character and holds its value while `rx_en` is 0. Bit 0 takes bit 0 of every processor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| guard_mode | input | 1 | Guard mode select for the transmit-end delay |
| block_mode | input | 1 | Block mode select for the transmit-end delay |
| etu_cycles | input | ETU_W | Elementary time unit length in clock cycles, at least 2 |
| cpu_rd | input | 1 | Processor read of the status byte |
| cpu_wr | input | 1 | Processor write of the status byte |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Current status byte |
| tx_load | input | 1 | Transmit data register moved into the shift register |
| tx_char_done | input | 1 | Last bit of a transmitted character has left |
| cpu_tdr_wr | input | 1 | Processor write of the transmit data register |
| dma_tdr_wr | input | 1 | DMA write of the transmit data register |
| rx_done | input | 1 | A received character is complete |
| rx_par_ok | input | 1 | Parity of the completed character matches the setting |
| rx_mpb | input | 1 | Multiprocessor bit of the completed character |
| dma_rdr_rd | input | 1 | DMA read of the receive data register |
| err_sig_low | input | 1 | Error signal sampled low during the guard time |
| rx_store | output | 1 | Capture the completed byte into the receive data register |
| rx_blocked | output | 1 | Reception frozen by a parity or overrun error |

## Verification
The bench targets the clear protocol. A design that accepted a 0 write without a prior read, or that treated a written 1 as a clear, would drop flags the processor never saw. It times transmit-end to the exact edge in all four mode combinations. A wrong half-etu count or a swapped mode decode would move the rising edge by whole half-etu steps. It also checks that a pending delay is cancelled by a data register write and suppressed by the error signal, where a faulty design would raise a spurious transmit end. For receive errors it looks at `rx_store` and receive-full together, so an overrun that overwrites the stored byte, or a parity error that sets receive-full, shows up at once. A long random run against a bench model then mixes every strobe with the read and write protocol.

// File: rtl/sc_status_pkg.sv
package sc_status_pkg;
   // Bit positions of the status byte (software decodes these).
   localparam int BIT_TX_EMPTY = 7;
   localparam int BIT_RX_FULL  = 6;
   localparam int BIT_OVERRUN  = 5;
   localparam int BIT_ERR_SIG  = 4;
   localparam int BIT_PAR_ERR  = 3;
   localparam int BIT_TX_END   = 2;
   localparam int BIT_MP_RX    = 1;
   localparam int BIT_MP_TX    = 0;
   // Flags that need the read-then-write-0 clear sequence occupy bits 7..3.
   localparam int CLR_LO   = 3;
   localparam int CLR_NUM  = 5;
   localparam int STAT_W   = 8;
   localparam logic [STAT_W-1:0] STAT_RESET = 8'h84;
endpackage

// File: rtl/sc_arm_latch.sv
module sc_arm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_rd,
   input  logic cpu_wr,
   input  logic wr_bit,
   input  logic flag_q,
   output logic clr_req
);
   logic arm_q;

   // A clear is allowed only once the flag has been observed as 1.
   assign clr_req = cpu_wr & arm_q & ~wr_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       arm_q <= 1'b0;
      else if (clr_req) arm_q <= 1'b0;
      else              arm_q <= (arm_q | cpu_rd) & flag_q;
   end

   assert_arm_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_q |=> !arm_q);
endmodule

// File: rtl/sc_tend_timer.sv
module sc_tend_timer #(
   parameter int ETU_W       = 16,
   parameter int HALF_G0_B0  = 5,
   parameter int HALF_G0_B1  = 3,
   parameter int HALF_G1     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cancel,
   input  logic             guard_mode,
   input  logic             block_mode,
   input  logic [ETU_W-1:0] etu_cycles,
   output logic             expire
);
   localparam int HMAX_A = (HALF_G0_B0 > HALF_G0_B1) ? HALF_G0_B0 : HALF_G0_B1;
   localparam int HMAX   = (HMAX_A > HALF_G1) ? HMAX_A : HALF_G1;
   localparam int HW     = $clog2(HMAX + 1);

   if (ETU_W < 2) begin : g_bad_etu_w
      $error("sc_tend_timer: ETU_W must be at least 2");
   end
   if (HALF_G0_B0 < 1 || HALF_G0_B1 < 1 || HALF_G1 < 1) begin : g_bad_half
      $error("sc_tend_timer: every delay needs at least one half-etu");
   end

   logic [ETU_W-1:0] half_len;
   logic [ETU_W-1:0] cyc_q;
   logic [HW-1:0]    halves_q;
   logic [HW-1:0]    target_q;
   logic [HW-1:0]    target_sel;
   logic             busy_q;
   logic             tick;

   assign half_len   = etu_cycles >> 1;
   assign target_sel = guard_mode ? HW'(HALF_G1)
                     : (block_mode ? HW'(HALF_G0_B1) : HW'(HALF_G0_B0));
   assign tick       = busy_q && (cyc_q == half_len - ETU_W'(1));
   assign expire     = tick && (halves_q == target_q - HW'(1)) && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         cyc_q    <= '0;
         halves_q <= '0;
         target_q <= '0;
      end else if (cancel) begin
         busy_q   <= 1'b0;
      end else if (start) begin
         busy_q   <= 1'b1;
         cyc_q    <= '0;
         halves_q <= '0;
         target_q <= target_sel;
      end else if (busy_q) begin
         if (tick) begin
            cyc_q <= '0;
            if (expire) busy_q   <= 1'b0;
            else        halves_q <= halves_q + HW'(1);
         end else begin
            cyc_q <= cyc_q + ETU_W'(1);
         end
      end
   end

   assert_etu_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (etu_cycles >= ETU_W'(2)));
   assert_cyc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cyc_q < half_len));
endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_en,
   input  logic rx_done,
   input  logic rx_par_ok,
   input  logic rx_mpb,
   input  logic dma_rdr_rd,
   input  logic clr_rdrf,
   input  logic clr_orer,
   input  logic clr_per,
   output logic rdrf_q,
   output logic orer_q,
   output logic per_q,
   output logic mpb_q,
   output logic rx_store,
   output logic rx_blocked
);
   logic rx_take;
   logic rx_ovr;
   logic rx_good;
   logic rx_bad;

   assign rx_blocked = per_q | orer_q;
   assign rx_take    = rx_en & rx_done & ~rx_blocked;
   assign rx_ovr     = rx_take & rdrf_q;
   assign rx_store   = rx_take & ~rdrf_q;
   assign rx_good    = rx_store & rx_par_ok;
   assign rx_bad     = rx_store & ~rx_par_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdrf_q <= 1'b0;
         orer_q <= 1'b0;
         per_q  <= 1'b0;
         mpb_q  <= 1'b0;
      end else begin
         if (rx_good)                     rdrf_q <= 1'b1;
         else if (clr_rdrf || dma_rdr_rd) rdrf_q <= 1'b0;
         if (rx_ovr)        orer_q <= 1'b1;
         else if (clr_orer) orer_q <= 1'b0;
         if (rx_bad)        per_q  <= 1'b1;
         else if (clr_per)  per_q  <= 1'b0;
         if (rx_store)      mpb_q  <= rx_mpb;
      end
   end

   assert_ovr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && rx_done && !rx_blocked && rdrf_q) |=> orer_q);
   assert_per_no_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && rx_done && !rx_blocked && !rdrf_q && !rx_par_ok) |=> (per_q && !rdrf_q));
   assert_blocked_mpb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_blocked |=> $stable(mpb_q));
   assert_rx_off_mpb_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> $stable(mpb_q));
   assert_rx_off_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !rdrf_q) |=> !rdrf_q);
endmodule

// File: rtl/sc_status_reg.sv
module sc_status_reg
   import sc_status_pkg::*;
#(
   parameter int ETU_W      = 16,
   parameter int HALF_G0_B0 = 5,
   parameter int HALF_G0_B1 = 3,
   parameter int HALF_G1    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              guard_mode,
   input  logic              block_mode,
   input  logic [ETU_W-1:0]  etu_cycles,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [STAT_W-1:0] cpu_wdata,
   output logic [STAT_W-1:0] cpu_rdata,
   input  logic              tx_load,
   input  logic              tx_char_done,
   input  logic              cpu_tdr_wr,
   input  logic              dma_tdr_wr,
   input  logic              rx_done,
   input  logic              rx_par_ok,
   input  logic              rx_mpb,
   input  logic              dma_rdr_rd,
   input  logic              err_sig_low,
   output logic              rx_store,
   output logic              rx_blocked
);
   localparam int CI_TDRE = BIT_TX_EMPTY - CLR_LO;
   localparam int CI_RDRF = BIT_RX_FULL  - CLR_LO;
   localparam int CI_ORER = BIT_OVERRUN  - CLR_LO;
   localparam int CI_ERS  = BIT_ERR_SIG  - CLR_LO;
   localparam int CI_PER  = BIT_PAR_ERR  - CLR_LO;

   logic [STAT_W-1:0]  stat;
   logic [CLR_NUM-1:0] clr;
   logic tdre_q, ers_q, tend_q, mpbt_q;
   logic rdrf_q, orer_q, per_q, mpb_q;
   logic tdre_clr, tend_set, t_expire, t_cancel;
   logic unused_wbits;

   assign unused_wbits = ^cpu_wdata[BIT_TX_END:BIT_MP_RX];

   assign stat[BIT_TX_EMPTY] = tdre_q;
   assign stat[BIT_RX_FULL]  = rdrf_q;
   assign stat[BIT_OVERRUN]  = orer_q;
   assign stat[BIT_ERR_SIG]  = ers_q;
   assign stat[BIT_PAR_ERR]  = per_q;
   assign stat[BIT_TX_END]   = tend_q;
   assign stat[BIT_MP_RX]    = mpb_q;
   assign stat[BIT_MP_TX]    = mpbt_q;
   assign cpu_rdata          = stat;

   for (genvar g = 0; g < CLR_NUM; g++) begin : g_arm
      sc_arm_latch i_arm (
         .clk     (clk),
         .rst_n   (rst_n),
         .cpu_rd  (cpu_rd),
         .cpu_wr  (cpu_wr),
         .wr_bit  (cpu_wdata[CLR_LO+g]),
         .flag_q  (stat[CLR_LO+g]),
         .clr_req (clr[g])
      );
   end

   assign t_cancel = cpu_tdr_wr | dma_tdr_wr | ~tx_en;

   sc_tend_timer #(
      .ETU_W      (ETU_W),
      .HALF_G0_B0 (HALF_G0_B0),
      .HALF_G0_B1 (HALF_G0_B1),
      .HALF_G1    (HALF_G1)
   ) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (tx_char_done),
      .cancel     (t_cancel),
      .guard_mode (guard_mode),
      .block_mode (block_mode),
      .etu_cycles (etu_cycles),
      .expire     (t_expire)
   );

   sc_rx_flags i_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_en      (rx_en),
      .rx_done    (rx_done),
      .rx_par_ok  (rx_par_ok),
      .rx_mpb     (rx_mpb),
      .dma_rdr_rd (dma_rdr_rd),
      .clr_rdrf   (clr[CI_RDRF]),
      .clr_orer   (clr[CI_ORER]),
      .clr_per    (clr[CI_PER]),
      .rdrf_q     (rdrf_q),
      .orer_q     (orer_q),
      .per_q      (per_q),
      .mpb_q      (mpb_q),
      .rx_store   (rx_store),
      .rx_blocked (rx_blocked)
   );

   assign tdre_clr = dma_tdr_wr | clr[CI_TDRE];
   assign tend_set = ~ers_q & (~tx_en | (t_expire & tdre_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdre_q <= STAT_RESET[BIT_TX_EMPTY];
         tend_q <= STAT_RESET[BIT_TX_END];
         ers_q  <= STAT_RESET[BIT_ERR_SIG];
         mpbt_q <= STAT_RESET[BIT_MP_TX];
      end else begin
         if (!tx_en || tx_load) tdre_q <= 1'b1;
         else if (tdre_clr)     tdre_q <= 1'b0;
         if (tend_set)          tend_q <= 1'b1;
         else if (tdre_clr)     tend_q <= 1'b0;
         if (err_sig_low)       ers_q  <= 1'b1;
         else if (clr[CI_ERS])  ers_q  <= 1'b0;
         if (cpu_wr)            mpbt_q <= cpu_wdata[BIT_MP_TX];
      end
   end

   assert_tdre_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> tdre_q);
   assert_tend_ers_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_q && !tend_q) |=> !tend_q);
   assert_ers_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_q && !cpu_wr) |=> ers_q);
endmodule

// File: tb/test_sc_status_reg.sv
`timescale 1ns/1ps
module test_sc_status_reg;
   localparam int ETU_W = 16;
   localparam int ETU   = 8;
   localparam int HALF  = ETU / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b1, rx_en = 1'b1, guard_mode = 1'b0, block_mode = 1'b0;
   logic [ETU_W-1:0] etu_cycles = ETU_W'(ETU);
   logic cpu_rd = 0, cpu_wr = 0;
   logic [7:0] cpu_wdata = 8'h00;
   logic [7:0] cpu_rdata;
   logic tx_load = 0, tx_char_done = 0, cpu_tdr_wr = 0, dma_tdr_wr = 0;
   logic rx_done = 0, rx_par_ok = 1, rx_mpb = 0, dma_rdr_rd = 0, err_sig_low = 0;
   logic rx_store, rx_blocked;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   sc_status_reg #(.ETU_W(ETU_W)) i_sc_status_reg (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
      .guard_mode(guard_mode), .block_mode(block_mode), .etu_cycles(etu_cycles),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .tx_load(tx_load), .tx_char_done(tx_char_done), .cpu_tdr_wr(cpu_tdr_wr),
      .dma_tdr_wr(dma_tdr_wr), .rx_done(rx_done), .rx_par_ok(rx_par_ok),
      .rx_mpb(rx_mpb), .dma_rdr_rd(dma_rdr_rd), .err_sig_low(err_sig_low),
      .rx_store(rx_store), .rx_blocked(rx_blocked)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic int exp_halves(input logic gm, input logic blk);
      if (gm) return 2;
      return blk ? 3 : 5;
   endfunction

   // processor read then write of one value
   task automatic rd_wr(input logic [7:0] d);
      cpu_rd = 1; tick(); cpu_rd = 0;
      cpu_wr = 1; cpu_wdata = d; tick(); cpu_wr = 0;
   endtask

   // clear transmit-empty and transmit-end, then reload transmit-empty
   task automatic prep_tx();
      rd_wr(8'h7F);
      tx_load = 1; tick(); tx_load = 0;
   endtask

   // ---------------- bench model for the random phase ----------------
   bit rnd_on = 0;
   logic m_tdre, m_rdrf, m_orer, m_ers, m_per, m_tend, m_mpb, m_mpbt;
   logic [4:0] m_arm, m_f, m_clr, m_arm_n;
   logic m_take, m_store, m_tclr;

   always @(posedge clk) if (rnd_on) begin
      m_f = {m_tdre, m_rdrf, m_orer, m_ers, m_per};
      for (int g = 0; g < 5; g++) begin
         m_clr[g]   = cpu_wr & m_arm[g] & ~cpu_wdata[3+g];
         m_arm_n[g] = m_clr[g] ? 1'b0 : ((m_arm[g] | cpu_rd) & m_f[g]);
      end
      m_take  = rx_en & rx_done & ~(m_per | m_orer);
      m_store = m_take & ~m_rdrf;
      m_tclr  = dma_tdr_wr | m_clr[4];
      m_tend  = (!tx_en && !m_ers) ? 1'b1 : (m_tclr ? 1'b0 : m_tend);
      m_tdre  = (!tx_en || tx_load) ? 1'b1 : (m_tclr ? 1'b0 : m_tdre);
      m_rdrf  = (m_store & rx_par_ok) ? 1'b1 : ((m_clr[3] | dma_rdr_rd) ? 1'b0 : m_rdrf);
      m_orer  = (m_take & m_f[3]) ? 1'b1 : (m_clr[2] ? 1'b0 : m_orer);
      m_ers   = err_sig_low ? 1'b1 : (m_clr[1] ? 1'b0 : m_ers);
      m_per   = (m_store & ~rx_par_ok) ? 1'b1 : (m_clr[0] ? 1'b0 : m_per);
      m_mpb   = m_store ? rx_mpb : m_mpb;
      m_mpbt  = cpu_wr ? cpu_wdata[0] : m_mpbt;
      m_arm   = m_arm_n;
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      int n;
      seed = $urandom(32'h5EED);
      repeat (3) tick();
      rst_n = 1;
      tick();
      chk("R1 reset byte", cpu_rdata, 8'h84);

      // R2: 0 without read, then 1 after read
      cpu_wr = 1; cpu_wdata = 8'h00; tick(); cpu_wr = 0;
      chk("R2 zero write without read", cpu_rdata, 8'h84);
      rd_wr(8'hFF);
      chk("R2 one write ignored, R12 mpbt", cpu_rdata, 8'h85);
      cpu_wr = 1; cpu_wdata = 8'h7E; tick(); cpu_wr = 0;
      chk("R2 R7 clear tdre and tend", cpu_rdata, 8'h00);

      // R3
      tx_load = 1; tick(); tx_load = 0;
      chk("R3 tx_load sets tdre", cpu_rdata, 8'h80);
      dma_tdr_wr = 1; tick(); dma_tdr_wr = 0;
      chk("R3 dma write clears tdre", cpu_rdata, 8'h00);
      tx_en = 0; tick(); tx_en = 1; tick();
      chk("R3 R7 tx disabled sets tdre tend", cpu_rdata, 8'h84);

      // R10 clean reception
      rx_done = 1; rx_par_ok = 1; rx_mpb = 1; #1;
      chk("R10 store on clean char", rx_store, 1);
      tick(); rx_done = 0;
      chk("R10 R12 rx full and mpb", cpu_rdata, 8'hC6);

      // R9 overrun
      rx_done = 1; rx_mpb = 0; #1;
      chk("R9 no store on overrun", rx_store, 0);
      tick(); rx_done = 0;
      chk("R9 overrun flag, byte dropped", cpu_rdata, 8'hE6);
      chk("R9 blocked", rx_blocked, 1);
      dma_rdr_rd = 1; tick(); dma_rdr_rd = 0;
      chk("R10 dma read clears rx full", cpu_rdata, 8'hA6);
      rx_done = 1; #1;
      chk("R9 blocked no store", rx_store, 0);
      tick(); rx_done = 0;
      chk("R9 blocked char ignored", cpu_rdata, 8'hA6);
      rd_wr(8'hDE);
      chk("R2 overrun cleared", cpu_rdata, 8'h86);

      // R8 parity error
      rx_done = 1; rx_par_ok = 0; rx_mpb = 0; #1;
      chk("R8 store on parity error", rx_store, 1);
      tick(); rx_done = 0; rx_par_ok = 1;
      chk("R8 per set, rx full stays 0", cpu_rdata, 8'h8C);
      rx_done = 1; rx_mpb = 1; #1;
      chk("R8 blocked no store", rx_store, 0);
      tick(); rx_done = 0;
      chk("R8 blocked char ignored", cpu_rdata, 8'h8C);
      rd_wr(8'hF7);
      chk("R2 per cleared", cpu_rdata, 8'h85);

      // R11 / R7 error signal
      rd_wr(8'h7F);
      chk("R2 tdre cleared", cpu_rdata, 8'h01);
      err_sig_low = 1; tick(); err_sig_low = 0;
      chk("R11 ers set", cpu_rdata, 8'h11);
      tx_en = 0; tick(); tx_en = 1; tick();
      chk("R11 R7 ers kept, tend held off", cpu_rdata, 8'h91);
      rd_wr(8'hEF);
      chk("R2 ers cleared", cpu_rdata, 8'h81);
      tx_en = 0; tick(); tx_en = 1; tick();
      chk("R7 tend set with ers 0", cpu_rdata, 8'h85);

      // R4 R5 R6 transmit-end timing
      for (int m = 0; m < 4; m++) begin
         logic gm, blk;
         gm = m[1]; blk = m[0];
         n = exp_halves(gm, blk) * HALF;
         prep_tx();
         guard_mode = gm; block_mode = blk;
         tx_char_done = 1; tick(); tx_char_done = 0;
         repeat (n - 1) tick();
         chk(gm ? "R6 tend low before delay" : (blk ? "R5 tend low before delay" : "R4 tend low before delay"),
             cpu_rdata[2], 0);
         tick();
         chk(gm ? "R6 tend at delay" : (blk ? "R5 tend at delay" : "R4 tend at delay"),
             cpu_rdata[2], 1);
      end

      // R7 cancel by data register write
      guard_mode = 0; block_mode = 0;
      prep_tx();
      tx_char_done = 1; tick(); tx_char_done = 0;
      repeat (3) tick();
      cpu_tdr_wr = 1; tick(); cpu_tdr_wr = 0;
      repeat (5 * HALF + 2) tick();
      chk("R7 cancelled delay", cpu_rdata[2], 0);

      // R7 error signal suppresses transmit-end
      prep_tx();
      err_sig_low = 1; tick(); err_sig_low = 0;
      tx_char_done = 1; tick(); tx_char_done = 0;
      repeat (5 * HALF + 2) tick();
      chk("R7 ers blocks tend", cpu_rdata, 8'h91);
      rd_wr(8'hEF);
      chk("R2 ers cleared again", cpu_rdata, 8'h81);

      // R11 R12 receiver disabled
      rx_en = 0; rx_done = 1; rx_par_ok = 1; rx_mpb = 1; #1;
      chk("R11 no store when rx off", rx_store, 0);
      tick(); rx_done = 0; rx_en = 1;
      chk("R11 R12 flags and mpb held", cpu_rdata, 8'h81);

      // random phase against bench model (R2 R3 R8 R9 R10 R11 R12)
      rst_n = 0; tick();
      m_tdre = 1; m_tend = 1; m_rdrf = 0; m_orer = 0; m_ers = 0; m_per = 0;
      m_mpb = 0; m_mpbt = 0; m_arm = '0;
      rst_n = 1; rnd_on = 1;
      for (int i = 0; i < 3000; i++) begin
         cpu_rd      = ($urandom % 10) < 3;
         cpu_wr      = ($urandom % 10) < 3;
         cpu_wdata   = 8'($urandom);
         rx_en       = ($urandom % 10) != 0;
         rx_done     = ($urandom % 5) == 0;
         rx_par_ok   = ($urandom % 4) != 0;
         rx_mpb      = 1'($urandom);
         dma_rdr_rd  = ($urandom % 10) == 0;
         tx_load     = ($urandom % 10) == 0;
         dma_tdr_wr  = ($urandom % 10) == 0;
         cpu_tdr_wr  = ($urandom % 10) == 0;
         err_sig_low = ($urandom % 20) == 0;
         tick();
         if (cpu_rdata !== {m_tdre, m_rdrf, m_orer, m_ers, m_per, m_tend, m_mpb, m_mpbt})
            chk("R2 random status byte", cpu_rdata,
                {m_tdre, m_rdrf, m_orer, m_ers, m_per, m_tend, m_mpb, m_mpbt});
         else if (i % 100 == 0) n_tests++;
      end
      rnd_on = 0;

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule